// File: doc/BRIEF.md
# Split-Lane Integer Multiply-Add Unit

This block divides one 48-bit multiply-add datapath into independent integer lanes. A build-time parameter picks one of two partitions. The two-lane partition has a wide lane and a narrow lane, each with a 24-bit add/subtract. The four-lane partition has one 7×6 lane and three 4×4 lanes, each with a 12-bit add/subtract. Each lane multiplies its own slices of the A and B inputs. It then adds or subtracts its own slice of C, which is extended to the lane width and shifted right by an amount kept for that lane.

All lanes share one signedness parameter and one 2-bit operation code. The per-lane overflow conditions are merged into one flag. Results and the flag are registered, so they appear one clock after the operands. No carry or borrow crosses from one lane into the next. The unit fits workloads that apply the same low-precision multiply-add to several narrow values packed into one word.

Top module: `simd_muladd`

## Requirements
- R1: With QUAD=0 there are two lanes of 24 bits each. Lane 0 multiplies 11 by 10 bits and lane 1 multiplies 8 by 8 bits. Both products are extended to 24 bits, and lane i drives y[24i+23:24i].
- R2: With QUAD=1 there are four lanes of 12 bits each. Lane 0 multiplies 7 by 6 bits and lanes 1 to 3 multiply 4 by 4 bits, with products extended to 12 bits. Lane i drives y[12i+11:12i].
- R3: Operand fields are packed from bit 0 upward in lane order. With QUAD=0, A is 11,8 bits, B is 10,8 bits and C is 9,9 bits. With QUAD=1, A is 7,4,4,4 bits, B is 6,4,4,4 bits and C is 6,4,4,4 bits.
- R4: The 13-bit product of the 7×6 lane keeps only its low 12 bits. With SIGNED=1, bit 11 of those 12 bits is then taken as the sign.
- R5: When bit i of C_LEFT is 0, the C slice of lane i is right-aligned and extended: sign-extended if SIGNED=1, zero-extended if SIGNED=0. When the bit is 1, the slice is placed at the top of the lane with zeros below it.
- R6: A clock edge with shift_load high stores the low 4 bits of each lane's C slice as that lane's shift amount, from 0 to 15. The extended C is shifted right by this amount: arithmetic if SIGNED=1, logical if SIGNED=0. The new amount applies to operands sampled at later edges.
- R7: With M the lane product and N the shifted C, op=00 gives M+N, 01 gives M-N, 10 gives -M+N and 11 gives -M-N. The low lane-width bits of the result are output.
- R8: A lane overflows when its exact result falls outside the lane range. That range is two's complement if SIGNED=1, and 0 to 2^W-1 if SIGNED=0. ovf is the OR of all lane overflows.
- R9: No lane result depends on the operand fields of another lane.
- R10: y and ovf are registered one cycle after the operands. A synchronous active-high rst clears y, ovf and every stored shift amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 19 | Packed multiplicand fields |
| b_in | input | 18 | Packed multiplier fields |
| c_in | input | 18 | Packed addend fields; also the source of shift amounts |
| op | input | 2 | Add/subtract selector shared by all lanes |
| shift_load | input | 1 | Store new per-lane shift amounts from c_in |
| y | output | 48 | Packed lane results |
| ovf | output | 1 | OR of the lane overflow conditions |

## Verification
The bench builds two instances side by side. The first is a signed four-lane build with lane 2 using left-aligned C. The second is an unsigned two-lane build with lane 1 using left-aligned C. Both instances receive the same input words, so one sweep exercises both signedness rules and both partitions. The sweep covers every operand pair of the truncated 7×6 lane, and each 4×4 lane sees a broad spread of its 256 pairs. Operation codes and shift reloads rotate throughout the sweep. Directed vectors then target extension, shift timing, saturating corners and reset of the stored shifts.

// File: rtl/simd_muladd.sv
module simd_muladd #(
  parameter bit         QUAD   = 1'b0,
  parameter bit         SIGNED = 1'b1,
  parameter logic [3:0] C_LEFT = 4'b0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [18:0] a_in,
  input  logic [17:0] b_in,
  input  logic [17:0] c_in,
  input  logic [1:0]  op,
  input  logic        shift_load,
  output logic [47:0] y,
  output logic        ovf
);
  localparam int LANES = QUAD ? 4 : 2;
  localparam int LW    = QUAD ? 12 : 24;
  localparam int XW    = LW + 2;

  function automatic int a_w(int i);
    if (QUAD) return (i == 0) ? 7 : 4;
    return (i == 0) ? 11 : 8;
  endfunction
  function automatic int b_w(int i);
    if (QUAD) return (i == 0) ? 6 : 4;
    return (i == 0) ? 10 : 8;
  endfunction
  function automatic int c_w(int i);
    if (QUAD) return (i == 0) ? 6 : 4;
    return 9;
  endfunction
  function automatic int a_o(int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += a_w(k);
    return s;
  endfunction
  function automatic int b_o(int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += b_w(k);
    return s;
  endfunction
  function automatic int c_o(int i);
    int s = 0;
    for (int k = 0; k < i; k++) s += c_w(k);
    return s;
  endfunction

  logic [LANES-1:0][LW-1:0] res;
  logic [LANES-1:0]         lane_ov;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int AW = a_w(i);
    localparam int BW = b_w(i);
    localparam int CW = c_w(i);
    localparam int PW = AW + BW;

    logic [AW-1:0] af;
    logic [BW-1:0] bf;
    logic [CW-1:0] cf;
    assign af = a_in[a_o(i) +: AW];
    assign bf = b_in[b_o(i) +: BW];
    assign cf = c_in[c_o(i) +: CW];

    logic signed [AW:0]   ax;
    logic signed [BW:0]   bx;
    logic signed [PW+1:0] prod;
    logic signed [XW-1:0] m;
    assign ax   = {SIGNED & af[AW-1], af};
    assign bx   = {SIGNED & bf[BW-1], bf};
    assign prod = ax * bx;

    if (PW > LW) begin : g_trunc
      assign m = {{2{SIGNED & prod[LW-1]}}, prod[LW-1:0]};
    end else begin : g_full
      assign m = {{(XW-PW-2){prod[PW+1]}}, prod};
    end

    logic [LW-1:0] ce;
    if (C_LEFT[i]) begin : g_left
      assign ce = {cf, {(LW-CW){1'b0}}};
    end else begin : g_right
      assign ce = {{(LW-CW){SIGNED & cf[CW-1]}}, cf};
    end

    logic [3:0] sh;
    always_ff @(posedge clk) begin
      if (rst)             sh <= '0;
      else if (shift_load) sh <= cf[3:0];
    end

    logic signed [LW-1:0] ces;
    logic        [LW-1:0] cs;
    assign ces = ce;
    if (SIGNED) begin : g_ashr
      assign cs = ces >>> sh;
    end else begin : g_lshr
      assign cs = ce >> sh;
    end

    logic signed [XW-1:0] n;
    logic signed [XW-1:0] s;
    assign n = {{2{SIGNED & cs[LW-1]}}, cs};

    always_comb begin
      case (op)
        2'b00:   s = m + n;
        2'b01:   s = m - n;
        2'b10:   s = n - m;
        default: s = -m - n;
      endcase
    end

    assign res[i] = s[LW-1:0];
    if (SIGNED) begin : g_sov
      assign lane_ov[i] = !((&s[XW-1:LW-1]) || !(|s[XW-1:LW-1]));
    end else begin : g_uov
      assign lane_ov[i] = |s[XW-1:LW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y   <= '0;
      ovf <= 1'b0;
    end else begin
      y   <= res;
      ovf <= |lane_ov;
    end
  end
endmodule

module simd_muladd_chk #(
  parameter bit         QUAD   = 1'b0,
  parameter bit         SIGNED = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic [18:0] a_in,
  input logic [17:0] b_in,
  input logic [17:0] c_in,
  input logic [1:0]  op,
  input logic        shift_load,
  input logic [47:0] y,
  input logic        ovf
);
  localparam int LW  = QUAD ? 12 : 24;
  localparam int W1  = QUAD ? 4 : 8;
  localparam int AO1 = QUAD ? 7 : 11;
  localparam int BO1 = QUAD ? 6 : 10;

  logic signed [W1:0]     a1, b1;
  logic signed [2*W1+1:0] p1;
  logic        [LW-1:0]   p1x;
  assign a1  = {SIGNED & a_in[AO1+W1-1], a_in[AO1 +: W1]};
  assign b1  = {SIGNED & b_in[BO1+W1-1], b_in[BO1 +: W1]};
  assign p1  = a1 * b1;
  assign p1x = {{(LW-2*W1-2){p1[2*W1+1]}}, p1};

  // R10
  reset_clear_chk: assert property (@(posedge clk) rst |=> (y == '0 && !ovf));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b00 && c_in == '0) |=> !ovf);

  // R9
  zero_operands_chk: assert property (@(posedge clk) disable iff (rst)
    (a_in == '0 && c_in == '0) |=> (y == '0 && !ovf));

  // R7
  lane1_product_chk: assert property (@(posedge clk) disable iff (rst)
    (op == 2'b00 && c_in == '0) |=> (y[LW +: LW] == $past(p1x)));
endmodule

bind simd_muladd simd_muladd_chk #(.QUAD(QUAD), .SIGNED(SIGNED)) u_chk (.*);

// File: tb/test_simd_muladd.sv
module test_simd_muladd;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [18:0] a   = '0;
  logic [17:0] b   = '0;
  logic [17:0] c   = '0;
  logic [1:0]  op  = '0;
  logic        ld  = 1'b0;
  logic [47:0] yq, yd;
  logic        ovq, ovd;
  int total = 0;
  int bad   = 0;
  int shq[4];
  int shd[2];

  always #5 clk = ~clk;

  simd_muladd #(.QUAD(1'b1), .SIGNED(1'b1), .C_LEFT(4'b0100)) i_simd_muladd (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .c_in(c), .op(op),
    .shift_load(ld), .y(yq), .ovf(ovq));

  simd_muladd #(.QUAD(1'b0), .SIGNED(1'b0), .C_LEFT(4'b0010)) i_simd_muladd_dual (
    .clk(clk), .rst(rst), .a_in(a), .b_in(b), .c_in(c), .op(op),
    .shift_load(ld), .y(yd), .ovf(ovd));

  function automatic int aw(bit qd, int i);
    return qd ? ((i == 0) ? 7 : 4) : ((i == 0) ? 11 : 8);
  endfunction
  function automatic int bw(bit qd, int i);
    return qd ? ((i == 0) ? 6 : 4) : ((i == 0) ? 10 : 8);
  endfunction
  function automatic int cw(bit qd, int i);
    return qd ? ((i == 0) ? 6 : 4) : 9;
  endfunction
  function automatic longint sx(longint v, int w, bit sgn);
    longint m = (longint'(1) << w) - 1;
    longint r = v & m;
    if (sgn && ((r >> (w - 1)) & 1)) r -= (longint'(1) << w);
    return r;
  endfunction

  function automatic void ref_lane(input bit qd, input bit sgn, input bit left, input int i,
                                   input int sh, output longint r, output bit ov);
    int lw = qd ? 12 : 24;
    int ao = 0, bo = 0, co = 0;
    longint av, bv, cv, p, ce, n, s;
    for (int k = 0; k < i; k++) begin
      ao += aw(qd, k); bo += bw(qd, k); co += cw(qd, k);
    end
    av = sx(longint'(a) >> ao, aw(qd, i), sgn);
    bv = sx(longint'(b) >> bo, bw(qd, i), sgn);
    p  = av * bv;
    if (aw(qd, i) + bw(qd, i) > lw) p = sx(p, lw, sgn);
    cv = (longint'(c) >> co) & ((longint'(1) << cw(qd, i)) - 1);
    if (left) ce = sx(cv << (lw - cw(qd, i)), lw, sgn);
    else      ce = sx(cv, cw(qd, i), sgn);
    n = ce >>> sh;
    case (op)
      2'b00:   s = p + n;
      2'b01:   s = p - n;
      2'b10:   s = n - p;
      default: s = -p - n;
    endcase
    if (sgn) ov = (s < -(longint'(1) << (lw - 1))) || (s >= (longint'(1) << (lw - 1)));
    else     ov = (s < 0) || (s >= (longint'(1) << lw));
    r = s & ((longint'(1) << lw) - 1);
  endfunction

  task automatic check_out(string tag);
    longint r;
    bit o, oq = 1'b0, od = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ref_lane(1'b1, 1'b1, (i == 2), i, shq[i], r, o);
      oq |= o;
      total++;
      if (longint'(yq[i*12 +: 12]) != r) begin
        bad++;
        $display("FAIL %s quad lane %0d: got %h expected %h", tag, i, yq[i*12 +: 12], r);
      end
    end
    for (int i = 0; i < 2; i++) begin
      ref_lane(1'b0, 1'b0, (i == 1), i, shd[i], r, o);
      od |= o;
      total++;
      if (longint'(yd[i*24 +: 24]) != r) begin
        bad++;
        $display("FAIL %s dual lane %0d: got %h expected %h", tag, i, yd[i*24 +: 24], r);
      end
    end
    total++;
    if (ovq !== oq || ovd !== od) begin
      bad++;
      $display("FAIL R8 (%s) ovf: got q=%b d=%b expected q=%b d=%b", tag, ovq, ovd, oq, od);
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge, then mirror any shift load.
  task automatic apply(logic [18:0] av, logic [17:0] bv, logic [17:0] cv, logic [1:0] ov,
                       logic lv, string tag);
    a = av; b = bv; c = cv; op = ov; ld = lv;
    @(negedge clk);
    check_out(tag);
    if (lv) begin
      shq[0] = int'(cv[3:0]);   shq[1] = int'(cv[9:6]);
      shq[2] = int'(cv[13:10]); shq[3] = int'(cv[17:14]);
      shd[0] = int'(cv[3:0]);   shd[1] = int'(cv[12:9]);
    end
    ld = 1'b0;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    foreach (shq[i]) shq[i] = 0;
    foreach (shd[i]) shd[i] = 0;
    a = 19'h7FFFF; b = 18'h3FFFF; c = 18'h3FFFF; op = 2'b11;
    repeat (3) @(negedge clk);
    total++;
    if (yq !== '0 || yd !== '0 || ovq !== 1'b0 || ovd !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset: got yq=%h yd=%h ovf=%b%b expected 0", yq, yd, ovq, ovd);
    end
    rst = 1'b0;

    // R3: distinct value in every field, no addend
    apply(19'h5A3C7, 18'h2B6D9, 18'h0, 2'b00, 1'b0, "R3");
    apply(19'h1F0E1, 18'h3C1E2, 18'h0, 2'b00, 1'b0, "R3");

    // R1 R2 R4 R9: exhaustive over the truncated lane, sweeping other lanes and ops
    for (int k = 0; k < 8192; k++) begin
      logic [18:0] av;
      logic [17:0] bv, cv;
      av = 19'(k & 127) | 19'(((k * 37) ^ (k >> 5)) << 7);
      bv = 18'(k >> 7)  | 18'(((k * 53) ^ (k >> 2)) << 6);
      cv = 18'((k * 40503) ^ (k >> 3));
      apply(av, bv, cv, 2'(k ^ (k >> 7)), (k % 97) == 0, "R1 R2 R4 R9");
    end

    // R5: zero A isolates the extended addend
    apply(19'h0, 18'h0, 18'h0, 2'b00, 1'b1, "R5");
    apply(19'h0, 18'h0, 18'h2AB5F, 2'b00, 1'b0, "R5");
    apply(19'h0, 18'h0, 18'h3FFFF, 2'b00, 1'b0, "R5");
    apply(19'h0, 18'h0, 18'h21021, 2'b10, 1'b0, "R5");

    // R6: load shifts, check the loading cycle uses the old amounts
    apply(19'h0, 18'h0, 18'h3AE5F, 2'b00, 1'b1, "R6");
    apply(19'h0, 18'h0, 18'h3AE5F, 2'b00, 1'b0, "R6");
    apply(19'h0, 18'h0, 18'h2492F, 2'b00, 1'b1, "R6");
    apply(19'h3, 18'h5, 18'h3FFFF, 2'b01, 1'b0, "R6");

    // R7: every op on one vector
    for (int o = 0; o < 4; o++) apply(19'h4B2D3, 18'h1A5C6, 18'h15A3B, 2'(o), 1'b0, "R7");

    // R8 R9: corners that wrap one lane while neighbours stay small
    apply(19'h7FFFF, 18'h3FFFF, 18'h3FFFF, 2'b00, 1'b0, "R8 R9");
    apply(19'h007FF, 18'h003FF, 18'h001FF, 2'b00, 1'b0, "R8 R9");
    apply(19'h40040, 18'h20020, 18'h20021, 2'b11, 1'b0, "R8 R9");
    apply(19'h00001, 18'h00001, 18'h00000, 2'b01, 1'b0, "R8");

    // R10: reset mid-run clears stored shifts
    apply(19'h0, 18'h0, 18'h3FFFF, 2'b00, 1'b1, "R10");
    rst = 1'b1;
    @(negedge clk);
    total++;
    if (yq !== '0 || yd !== '0 || ovq !== 1'b0 || ovd !== 1'b0) begin
      bad++;
      $display("FAIL R10 mid reset: got yq=%h yd=%h ovf=%b%b expected 0", yq, yd, ovq, ovd);
    end
    rst = 1'b0;
    foreach (shq[i]) shq[i] = 0;
    foreach (shd[i]) shd[i] = 0;
    apply(19'h0, 18'h0, 18'h3FFFF, 2'b00, 1'b0, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule